// File: doc/BRIEF.md
# Manchester Word Decoder with Sync Identification

This block receives a serial Manchester-coded stream and turns it into NRZ bits with word framing. The line is sampled by a local clock that runs at twelve times the bit rate. A transition finder re-aligns a half-bit phase counter on every observed edge and takes one sample near the centre of each half-bit cell. A framer then searches those half-bit samples for a sync pulse, tells a command-type sync from a data-type sync, and decodes a fixed-length word of data bits followed by a parity bit.

The line level comes either from a pair of bipolar lines or from one unipolar input. For the unipolar input, the bipolar-zero line is held high and the bipolar-one line is held low. When the external-sync select is high, the half-bit samples come instead from an external data input, taken on each rising edge of an external half-bit clock. That path bypasses the transition finder. All logic runs on the one sampling clock. The external clock is brought in as a data signal and used as a strobe, not as a clock.

Top module: `mdec_decoder`

## Requirements
- R1: An active-low reset, at any time (also in the middle of a word), drives take_data, take_free, ser_data, shift_clk, cmd_sync, data_sync and valid_word low and returns the framer to sync search.
- R2: A sync pulse of 1.5 bit times high followed by 1.5 bit times low is a command sync. cmd_sync goes high, and data_sync stays low, in the same cycle that take_data rises. The flags hold until take_data next rises, and they are never both high.
- R3: A sync pulse of 1.5 bit times low followed by 1.5 bit times high is a data sync. data_sync goes high, and cmd_sync stays low, in the same cycle that take_data rises.
- R4: A bit is coded high-then-low for 1 and low-then-high for 0. After a sync, exactly DATA_BITS+1 one-cycle shift_clk pulses follow: the data bits MSB first, then the parity bit. ser_data carries each bit's NRZ value in its pulse cycle.
- R5: take_data is low during the first bit's pulse and rises in the cycle of the second bit's pulse, provided neither of the first two bits had a coding error. It stays high through the pulse of the last data bit and drops in the cycle of the parity bit's pulse.
- R6: valid_word is set in the cycle of the parity bit's pulse when the word has no coding error and the count of ones over the data bits and the parity bit is odd. It then holds until the next sync is found.
- R7: A word whose ones count (data plus parity) is even ends with valid_word low.
- R8: When par_even is high, the parity sense is inverted: an even ones count is accepted and an odd count is rejected.
- R9: A bit cell whose two half-bit samples are equal is a coding error. valid_word stays low at the end of that word, but the remaining bits are still shifted out. When the error is in the first bit, the framer drops the candidate sync, gives no pulse for that bit, and resumes sync search.
- R10: Bipolar input (one line high for a positive bus, the other line high for a negative bus) and unipolar input (zero line high, one line low, data on the unipolar input) decode the same words identically.
- R11: With ext_sel high, each rising edge of ext_clk supplies one half-bit sample taken from ext_data, and the words decode as in R2 to R6.
- R12: take_free equals take_data while a word is being received. Outside a word, it toggles once per half-bit sample, which gives a square wave at the bit rate.
- R13: Words whose mid-bit transitions are all shifted by +2 or by -2 sample clocks from nominal decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bip_one | input | 1 | High while the bus is positive; low in unipolar use |
| bip_zero | input | 1 | High while the bus is negative; high in unipolar use |
| uni_in | input | 1 | Unipolar line data; low when unused |
| par_even | input | 1 | Inverts the parity sense |
| ext_sel | input | 1 | Selects the external half-bit clock/data path |
| ext_clk | input | 1 | External half-bit clock, one rising edge per half bit |
| ext_data | input | 1 | External Manchester data |
| take_data | output | 1 | Word data present |
| take_free | output | 1 | Free-running timing copy of take_data |
| ser_data | output | 1 | Received bit in NRZ form |
| shift_clk | output | 1 | One-cycle pulse per received bit |
| cmd_sync | output | 1 | Last accepted word began with a command sync |
| data_sync | output | 1 | Last accepted word began with a data sync |
| valid_word | output | 1 | Last word had good parity and no coding error |

## Verification
A phase counter that drifts, or that fails to re-zero on an edge, shows up at once as a wrong ser_data bit or a missing shift_clk pulse within the same word. Comparing all captured bits of every word exposes it inside one bit time. A framer that mistakes the sync type, or miscounts bits, gives wrong cmd_sync/data_sync values, or a take_data window that is off by one pulse, in the second bit of the word. Corrupted parity or error tracking only becomes visible in the parity bit's pulse cycle, where valid_word is compared with a value the bench computes from the transmitted bits and par_even.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_WORD = 1'b1
    } fr_state_e;

    // sync pulse spans six half-bit samples
    localparam int SYNC_HALVES = 6;
    localparam logic [SYNC_HALVES-1:0] PAT_CMD = 6'b111000;
    localparam logic [SYNC_HALVES-1:0] PAT_DAT = 6'b000111;
endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mdec_phase.sv
module mdec_phase #(
    parameter int OVS    = 12,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bip_one,
    input  logic bip_zero,
    input  logic uni_in,
    input  logic ext_sel,
    input  logic ext_clk,
    input  logic ext_data,
    output logic hs_vld,
    output logic hs_bit
);
    localparam int HALF = OVS / 2;
    localparam int MID  = HALF / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic       line;
    logic [2:0] raw;
    logic [2:0] syn;

    // bipolar: one-line carries level, zero-line is its complement
    // unipolar: zero-line tied high, one-line tied low, level on uni_in
    assign line = bip_one | (bip_zero & uni_in);
    assign raw  = {ext_data, ext_clk, line};

    mdec_sync #(.W(3), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    typedef struct packed {
        logic          line_p;
        logic          eclk_p;
        logic [CW-1:0] cnt;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d        = ph_q;
        ph_d.line_p = syn[0];
        ph_d.eclk_p = syn[1];
        if (syn[0] != ph_q.line_p) begin
            ph_d.cnt = CW'(1);
        end else if (ph_q.cnt == CW'(HALF - 1)) begin
            ph_d.cnt = '0;
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end

        if (ext_sel) begin
            hs_vld = syn[1] & ~ph_q.eclk_p;
            hs_bit = syn[2];
        end else begin
            hs_vld = (ph_q.cnt == CW'(MID));
            hs_bit = syn[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/mdec_framer.sv
module mdec_framer
    import mdec_pkg::*;
#(
    parameter int DATA_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_vld,
    input  logic hs_bit,
    input  logic par_even,
    output logic take_data,
    output logic take_free,
    output logic ser_data,
    output logic shift_clk,
    output logic cmd_sync,
    output logic data_sync,
    output logic valid_word
);
    localparam int WORD_BITS = DATA_BITS + 1;
    localparam int CW        = $clog2(WORD_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

    typedef struct packed {
        fr_state_e             st;
        logic [SYNC_HALVES-1:0] hist;
        logic                  first;
        logic                  half;
        logic [CW-1:0]         cnt;
        logic                  par;
        logic                  err;
        logic                  is_cmd;
        logic                  take;
        logic                  cmd_f;
        logic                  dat_f;
        logic                  valid;
        logic                  ser;
        logic                  sclk;
        logic                  free;
    } fr_t;

    fr_t fr_d, fr_q;
    logic [SYNC_HALVES-1:0] hist_n;
    logic                   bad;
    logic                   err_n;
    logic                   par_n;

    always_comb begin
        fr_d      = fr_q;
        fr_d.sclk = 1'b0;
        hist_n    = {fr_q.hist[SYNC_HALVES-2:0], hs_bit};
        bad       = (fr_q.first == hs_bit);
        err_n     = fr_q.err | bad;
        par_n     = fr_q.par ^ fr_q.first;

        if (hs_vld) begin
            fr_d.hist = hist_n;
            fr_d.free = ~fr_q.free;
            unique case (fr_q.st)
                FR_HUNT: begin
                    if (hist_n == PAT_CMD || hist_n == PAT_DAT) begin
                        fr_d.st     = FR_WORD;
                        fr_d.is_cmd = (hist_n == PAT_CMD);
                        fr_d.half   = 1'b0;
                        fr_d.cnt    = '0;
                        fr_d.par    = 1'b0;
                        fr_d.err    = 1'b0;
                        fr_d.valid  = 1'b0;
                    end
                end
                FR_WORD: begin
                    if (!fr_q.half) begin
                        fr_d.first = hs_bit;
                        fr_d.half  = 1'b1;
                    end else begin
                        fr_d.half = 1'b0;
                        if (bad && fr_q.cnt == '0) begin
                            // candidate sync rejected: keep hunting
                            fr_d.st = FR_HUNT;
                        end else begin
                            fr_d.ser  = fr_q.first;
                            fr_d.sclk = 1'b1;
                            fr_d.par  = par_n;
                            fr_d.err  = err_n;
                            fr_d.cnt  = fr_q.cnt + 1'b1;
                            if (fr_q.cnt == CW'(1) && !err_n) begin
                                fr_d.take  = 1'b1;
                                fr_d.cmd_f = fr_q.is_cmd;
                                fr_d.dat_f = ~fr_q.is_cmd;
                            end
                            if (fr_q.cnt == LAST) begin
                                fr_d.take  = 1'b0;
                                fr_d.st    = FR_HUNT;
                                fr_d.valid = ~err_n & (par_n ^ par_even);
                            end
                        end
                    end
                end
                default: fr_d.st = FR_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign take_data  = fr_q.take;
    assign take_free  = (fr_q.st == FR_WORD) ? fr_q.take : fr_q.free;
    assign ser_data   = fr_q.ser;
    assign shift_clk  = fr_q.sclk;
    assign cmd_sync   = fr_q.cmd_f;
    assign data_sync  = fr_q.dat_f;
    assign valid_word = fr_q.valid;
endmodule

// File: rtl/mdec_decoder.sv
module mdec_decoder #(
    parameter int OVS         = 12,
    parameter int DATA_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bip_one,
    input  logic bip_zero,
    input  logic uni_in,
    input  logic par_even,
    input  logic ext_sel,
    input  logic ext_clk,
    input  logic ext_data,
    output logic take_data,
    output logic take_free,
    output logic ser_data,
    output logic shift_clk,
    output logic cmd_sync,
    output logic data_sync,
    output logic valid_word
);
    logic hs_vld;
    logic hs_bit;

    mdec_phase #(.OVS(OVS), .STAGES(SYNC_STAGES)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bip_one  (bip_one),
        .bip_zero (bip_zero),
        .uni_in   (uni_in),
        .ext_sel  (ext_sel),
        .ext_clk  (ext_clk),
        .ext_data (ext_data),
        .hs_vld   (hs_vld),
        .hs_bit   (hs_bit)
    );

    mdec_framer #(.DATA_BITS(DATA_BITS)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_vld     (hs_vld),
        .hs_bit     (hs_bit),
        .par_even   (par_even),
        .take_data  (take_data),
        .take_free  (take_free),
        .ser_data   (ser_data),
        .shift_clk  (shift_clk),
        .cmd_sync   (cmd_sync),
        .data_sync  (data_sync),
        .valid_word (valid_word)
    );
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker (
    input logic clk,
    input logic rst_n,
    input logic take_data,
    input logic take_free,
    input logic shift_clk,
    input logic cmd_sync,
    input logic data_sync,
    input logic valid_word
);
    assert_take_rise_on_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_data) |-> shift_clk);

    assert_valid_ends_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_word) |-> $fell(take_data));

    assert_sync_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_sync, data_sync}));

    // R3: the data-sync flag appears only together with the take window
    assert_data_flag_with_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_sync) |-> $rose(take_data));

    assert_shift_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |=> !shift_clk);

    assert_free_follows_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |-> take_free);
endmodule

bind mdec_decoder mdec_checker i_mdec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_data  (take_data),
    .take_free  (take_free),
    .shift_clk  (shift_clk),
    .cmd_sync   (cmd_sync),
    .data_sync  (data_sync),
    .valid_word (valid_word)
);

// File: tb/test_mdec_decoder.sv
module test_mdec_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bip_one = 1'b0, bip_zero = 1'b1, uni_in = 1'b0;
    logic par_even = 1'b0, ext_sel = 1'b0, ext_clk = 1'b0, ext_data = 1'b0;
    logic take_data, take_free, ser_data, shift_clk, cmd_sync, data_sync, valid_word;

    always #4 clk = ~clk;

    mdec_decoder i_mdec_decoder (
        .clk(clk), .rst_n(rst_n), .bip_one(bip_one), .bip_zero(bip_zero),
        .uni_in(uni_in), .par_even(par_even), .ext_sel(ext_sel),
        .ext_clk(ext_clk), .ext_data(ext_data), .take_data(take_data),
        .take_free(take_free), .ser_data(ser_data), .shift_clk(shift_clk),
        .cmd_sync(cmd_sync), .data_sync(data_sync), .valid_word(valid_word)
    );

    int checks = 0;
    int failures = 0;
    int mode = 0;   // 0 bipolar, 1 unipolar, 2 external path
    int npulse = 0;
    logic cap [32];
    logic tk  [32];
    logic tf  [32];
    logic cf  [32];
    logic df  [32];
    logic vw  [32];
    logic cnt_free = 1'b0;
    int   free_tog = 0;
    logic free_p = 1'b0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (shift_clk && npulse < 32) begin
            cap[npulse] = ser_data;
            tk[npulse]  = take_data;
            tf[npulse]  = take_free;
            cf[npulse]  = cmd_sync;
            df[npulse]  = data_sync;
            vw[npulse]  = valid_word;
            npulse      = npulse + 1;
        end
        if (cnt_free && take_free != free_p) free_tog = free_tog + 1;
        free_p = take_free;
    end

    task automatic set_line(input logic lv);
        if (mode == 1) begin
            bip_one = 1'b0; bip_zero = 1'b1; uni_in = lv;
        end else if (mode == 0) begin
            bip_one = lv; bip_zero = ~lv; uni_in = 1'b0;
        end else begin
            bip_one = 1'b0; bip_zero = 1'b1; uni_in = 1'b0;
        end
    endtask

    task automatic put_half(input logic lv, input int n);
        if (mode == 2) begin
            ext_data = lv; ext_clk = 1'b1;
            repeat (n / 2) @(negedge clk);
            ext_clk = 1'b0;
            repeat (n - n / 2) @(negedge clk);
        end else begin
            set_line(lv);
            repeat (n) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        ext_clk = 1'b0;
        set_line(1'b0);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic cmd, input logic [15:0] data, input logic flip,
                             input int err_bit, input int jit, input int nbits);
        logic p;
        logic b;
        p = ~(^data) ^ flip;
        npulse = 0;
        for (int k = 0; k < 3; k++) put_half(cmd, 6);
        for (int k = 0; k < 3; k++) put_half(~cmd, 6);
        for (int i = 0; i < nbits; i++) begin
            b = (i < 16) ? data[15-i] : p;
            if (i == err_bit) begin
                put_half(b, 6 + jit); put_half(b, 6 - jit);
            end else begin
                put_half(b, 6 + jit); put_half(~b, 6 - jit);
            end
        end
    endtask

    task automatic run_word(input logic cmd, input logic [15:0] data, input logic flip,
                            input int err_bit, input int jit, input string vreq);
        logic p;
        logic expv;
        int   bad;
        p    = ~(^data) ^ flip;
        expv = (err_bit < 0) && ((^{data, p}) ^ par_even);
        send_word(cmd, data, flip, err_bit, jit, 17);
        idle(48);
        check(npulse == 17, "R4 pulse count", npulse, 17);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (i != err_bit && cap[i] != data[15-i]) bad++;
            if (i == err_bit && cap[i] != data[15-i]) bad++;
        end
        check(bad == 0, (jit != 0) ? "R13 data bits" : ((mode == 2) ? "R11 data bits" : "R4 data bits"), bad, 0);
        check(cap[16] == p, "R4 parity bit", int'(cap[16]), int'(p));
        bad = 0;
        if (tk[0] != 1'b0) bad++;
        for (int i = 1; i < 16; i++) if (tk[i] != 1'b1) bad++;
        if (tk[16] != 1'b0) bad++;
        check(bad == 0, "R5 take window", bad, 0);
        check(cf[1] == cmd, cmd ? "R2 cmd flag" : "R3 cmd flag", int'(cf[1]), int'(cmd));
        check(df[1] == ~cmd, cmd ? "R2 data flag" : "R3 data flag", int'(df[1]), int'(~cmd));
        check(vw[16] == expv, vreq, int'(vw[16]), int'(expv));
        check(valid_word == expv, "R6 valid held", int'(valid_word), int'(expv));
        bad = 0;
        for (int i = 1; i < 16; i++) if (tf[i] != tk[i]) bad++;
        check(bad == 0, "R12 free copy in word", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(4);
        check({take_data, take_free, ser_data, shift_clk, cmd_sync, data_sync, valid_word} == 7'd0,
              "R1 reset state", 0, 0);
        rst_n = 1'b1;
        idle(60);

        mode = 0;
        run_word(1'b1, 16'hA5C3, 1'b0, -1, 0, "R6 valid good word");
        run_word(1'b0, 16'h0000, 1'b0, -1, 0, "R6 valid data sync");
        mode = 1;
        run_word(1'b1, 16'hFFFF, 1'b0, -1, 0, "R10 unipolar valid");
        run_word(1'b0, 16'h1234, 1'b1, -1, 0, "R7 bad parity");
        mode = 0;
        run_word(1'b1, 16'h8001, 1'b1, -1, 0, "R7 bad parity bipolar");
        par_even = 1'b1;
        run_word(1'b1, 16'h7E3C, 1'b0, -1, 0, "R8 odd rejected");
        run_word(1'b0, 16'h7E3C, 1'b1, -1, 0, "R8 even accepted");
        par_even = 1'b0;
        run_word(1'b1, 16'hC0DE, 1'b0, 5, 0, "R9 coding error");
        run_word(1'b0, 16'h3E5A, 1'b0, 15, 0, "R9 coding error late");
        run_word(1'b1, 16'h9B71, 1'b0, -1, 2, "R13 late mid");
        run_word(1'b0, 16'h9B71, 1'b0, -1, -2, "R13 early mid");

        // R12: free-running toggle outside a word
        idle(12);
        free_tog = 0; cnt_free = 1'b1;
        idle(120);
        cnt_free = 1'b0;
        check(free_tog >= 19 && free_tog <= 21, "R12 free toggle rate", free_tog, 20);

        mode = 2; ext_sel = 1'b1;
        idle(24);
        run_word(1'b1, 16'h5A5A, 1'b0, -1, 0, "R11 external valid");
        run_word(1'b0, 16'h0F0F, 1'b1, -1, 0, "R11 external bad parity");
        ext_sel = 1'b0; mode = 0;
        idle(60);

        // sweep: walking ones over both input styles and sync types
        for (int i = 0; i < 16; i++) begin
            mode = i % 2;
            run_word(i[1], (16'h1 << i) ^ (16'h0F0F * i[2]), i[3], -1, 0,
                     (i % 2) ? "R10 sweep unipolar" : "R6 sweep bipolar");
        end
        mode = 0;

        // R1: reset in the middle of a word
        send_word(1'b1, 16'hFACE, 1'b0, -1, 0, 6);
        check(take_data == 1'b1, "R5 take mid word", int'(take_data), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({take_data, take_free, ser_data, shift_clk, cmd_sync, data_sync, valid_word} == 7'd0,
              "R1 mid-word reset", int'({take_data, cmd_sync, valid_word}), 0);
        rst_n = 1'b1;
        idle(60);
        run_word(1'b0, 16'hBEEF, 1'b0, -1, 0, "R1 word after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule